// File: doc/BRIEF.md
# Four-Channel RC-Charge Conversion Timer

This block measures four analog voltages by timing how long an external RC network takes to charge up to the threshold of a comparator. Each channel has a discharge drive output that shorts its capacitor while a conversion is being prepared. It also has a free-running counter and a stop flag. When the comparator trips, the stop flag latches and the counter freezes. Firmware then reads the frozen count as a measure of the analog input.

Firmware starts a conversion by writing a control byte that turns the channel's discharge drive off and enables its counter in the same write. The capacitor then charges while the counter runs. A rising comparator edge stops the count. Firmware can read a status byte that shows which channels have stopped and which of them raise an interrupt request. Each request is gated by an externally supplied enable bit. Writing 0 to a channel's counter-enable bit clears its count and its stop flag, which readies the channel for the next conversion.

Top module: `rct_adc_timer`

## Requirements
- R1: After reset the control byte, status byte, discharge outputs, interrupt requests and every count are zero.
- R2: A write with `bus_addr`=0 loads the control byte, and reading address 0 returns the last value written. In the control byte, bit 4+i is the discharge control of channel i and bit i is the counter enable of channel i, for i=0..3.
- R3: `discharge_on[i]` equals control bit 4+i, so 1 holds the capacitor discharged and 0 lets it charge.
- R4: While control bit i is 0, channel i holds its count at zero and its stop flag clear, one clock after the write takes effect. When bit i is 1, the count increments once per clock, starting with the first edge after the write edge.
- R5: The comparator input passes through a two-flop synchronizer. Suppose the input rises m clocks after the enabling write edge and before that channel's next edge. The stop flag is then set on the third following edge, and the count freezes at m+2, limited by saturation.
- R6: A stopped channel keeps its count and stop flag, whatever further comparator edges arrive, until its counter is cleared.
- R7: A running counter saturates at all ones instead of wrapping.
- R8: A comparator rise while the counter is cleared has no effect. A comparator that is already high when the counter is enabled does not stop it.
- R9: Reading `bus_addr`=1 returns the status byte. Bit 4+i is the interrupt request of channel i and bit i is the stop flag of channel i.
- R10: `irq_req[i]` is 1 exactly when channel i is stopped and `irq_enable[i]` is 1, and status bits 7:4 show the same values.
- R11: A write to address 1 changes neither the status byte nor the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 control, 1 status |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| cmp_in | input | 4 | Asynchronous comparator outputs, one per channel |
| irq_enable | input | 4 | Per-channel interrupt enables |
| discharge_on | output | 4 | Discharge transistor drives |
| irq_req | output | 4 | Per-channel interrupt requests |
| count_out | output | 64 | Channel counts, channel i at bits 16i+15:16i |

## Verification
The hardest state to reach is a comparator edge landing exactly on a chosen count. This is hardest near saturation, where freezing and saturating can happen on the same edge. The bench sweeps the delay between the enabling write and the comparator rise over every value up to past the saturation point, on each channel in turn, with a narrow 6-bit counter. It then predicts the frozen value as the delay plus two, capped at the all-ones count. It also holds a comparator high across the enabling write, so that the case of a level with no edge is exercised.

// File: rtl/rct_pkg.sv
// Shared definitions for the RC-charge conversion timer.
// Assumes a one-bit register select on the host bus.
package rct_pkg;
    typedef enum logic {
        REG_CTRL = 1'b0,
        REG_STAT = 1'b1
    } rct_reg_e;
endpackage

// File: rtl/rct_sync.sv
// Synchronizes one asynchronous comparator level and flags its rising edge.
// Assumes STAGES >= 2. The output pulse lasts one clock.
module rct_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the raw level through the synchronizer and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    // A rise is the synchronized level high while its delayed copy is low.
    always_comb rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/rct_channel.sv
// One conversion channel: a saturating counter and a stop flag.
// Assumes run comes from a register and rise is a synchronized one-clock pulse.
module rct_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             rise,
    output logic [CNT_W-1:0] count,
    output logic             stopped
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] count_q;
    logic             stop_q;

    // Clear when not running, freeze on a comparator rise, otherwise count up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            stop_q  <= 1'b0;
        end else if (!run) begin
            count_q <= '0;
            stop_q  <= 1'b0;
        end else if (stop_q) begin
            count_q <= count_q;
        end else if (rise) begin
            stop_q  <= 1'b1;
        end else if (count_q != CNT_MAX) begin
            count_q <= count_q + 1'b1;
        end
    end

    always_comb begin
        count   = count_q;
        stopped = stop_q;
    end

    // R4: a cleared channel reads zero and not stopped on the next clock
    a_r4_clear_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (count_q == '0) && !stop_q);

    // R5: the stop flag only rises after a synchronized edge seen while running
    a_r5_stop_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_q) |-> $past(rise && run));

    // R6: a channel that stays stopped keeps its count
    a_r6_frozen_count: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q |=> (!stop_q || $stable(count_q)));

    // R7: the counter never wraps from all ones to a nonzero value
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CNT_MAX) |=> (count_q == CNT_MAX) || (count_q == '0));
endmodule

// File: rtl/rct_regs.sv
// Host register file: the read/write control byte and the read-only status byte.
// Assumes a single-cycle write strobe and a combinational read.
module rct_regs
    import rct_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int REG_W = 2 * NUM_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_addr,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    input  logic [REG_W-1:0] stat_in,
    output logic [REG_W-1:0] ctrl,
    output logic [REG_W-1:0] rdata
);
    logic [REG_W-1:0] ctrl_q;

    // Load the control byte on a write to its address; other writes are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (bus_wr && (bus_addr == REG_CTRL)) begin
            ctrl_q <= bus_wdata;
        end
    end

    // Select the register named by the address for reading.
    always_comb begin
        ctrl  = ctrl_q;
        rdata = (bus_addr == REG_STAT) ? stat_in : ctrl_q;
    end

    // R2: a control write is visible on the next clock
    a_r2_ctrl_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_CTRL) |=> (ctrl_q == $past(bus_wdata)));

    // R11: a status write leaves the control byte alone
    a_r11_stat_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_STAT) |=> $stable(ctrl_q));
endmodule

// File: rtl/rct_adc_timer.sv
// Four-channel RC-charge conversion timer top level.
// Control bits NUM_CH+i drive discharge and bits i enable counters; status packs
// interrupt requests above stop flags. Assumes comparator inputs are asynchronous.
module rct_adc_timer #(
    parameter int NUM_CH      = 4,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int REG_W      = 2 * NUM_CH
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_addr,
    input  logic                    bus_wr,
    input  logic [REG_W-1:0]        bus_wdata,
    output logic [REG_W-1:0]        bus_rdata,
    input  logic [NUM_CH-1:0]       cmp_in,
    input  logic [NUM_CH-1:0]       irq_enable,
    output logic [NUM_CH-1:0]       discharge_on,
    output logic [NUM_CH-1:0]       irq_req,
    output logic [NUM_CH*CNT_W-1:0] count_out
);
    logic [REG_W-1:0]  ctrl;
    logic [REG_W-1:0]  stat;
    logic [NUM_CH-1:0] rise;
    logic [NUM_CH-1:0] stopped;

    rct_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .stat_in   (stat),
        .ctrl      (ctrl),
        .rdata     (bus_rdata)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        rct_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (cmp_in[ch]),
            .rise     (rise[ch])
        );

        rct_channel #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (ctrl[ch]),
            .rise    (rise[ch]),
            .count   (count_out[ch*CNT_W +: CNT_W]),
            .stopped (stopped[ch])
        );
    end

    // Route discharge drives, gate interrupt requests and pack the status byte.
    always_comb begin
        discharge_on = ctrl[REG_W-1:NUM_CH];
        irq_req      = stopped & irq_enable;
        stat         = {irq_req, stopped};
    end
endmodule

// File: tb/test_rct_adc_timer.sv
`timescale 1ns/1ps
module test_rct_adc_timer;
    localparam int NCH = 4;
    localparam int CW  = 6;
    localparam int MAXC = (1 << CW) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_addr = 1'b0;
    logic           bus_wr = 1'b0;
    logic [7:0]     bus_wdata = '0;
    logic [7:0]     bus_rdata;
    logic [NCH-1:0] cmp_in = '0;
    logic [NCH-1:0] irq_enable = '0;
    logic [NCH-1:0] discharge_on;
    logic [NCH-1:0] irq_req;
    logic [NCH*CW-1:0] count_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rct_adc_timer #(.NUM_CH(NCH), .CNT_W(CW), .SYNC_STAGES(2)) i_rct_adc_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
        .irq_enable(irq_enable), .discharge_on(discharge_on), .irq_req(irq_req),
        .count_out(count_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    function automatic int rd(input logic a);
        bus_addr = a;
        return 0;
    endfunction

    task automatic read(input logic a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    function automatic int cnt(input int ch);
        return int'(count_out[ch*CW +: CW]);
    endfunction

    initial begin
        int v;
        int exp;
        int junk;
        junk = rd(1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read(1'b0, v); chk("R1 control after reset", v, 0);
        read(1'b1, v); chk("R1 status after reset", v, 0);
        chk("R1 discharge after reset", int'(discharge_on), 0);
        chk("R1 irq after reset", int'(irq_req), 0);
        chk("R1 counts after reset", int'(count_out), 0);

        // R2 / R3 full sweep of control values, comparators low
        for (int d = 0; d < 256; d++) begin
            wr(1'b0, d[7:0]);
            read(1'b0, v); chk("R2 control readback", v, d);
            chk("R3 discharge drive", int'(discharge_on), d >> 4);
        end
        wr(1'b0, 8'h00);
        edges(1);
        chk("R4 all counts cleared", int'(count_out), 0);

        // R5 / R6 / R9 / R10 / R4 sweep of trip delay on each channel
        for (int ch = 0; ch < NCH; ch++) begin
            for (int m = 0; m < 68; m++) begin
                irq_enable = m[3:0];
                wr(1'b0, 8'(8'h10 << ch));
                chk("R3 discharge on while prepared", int'(discharge_on), 1 << ch);
                wr(1'b0, 8'(1 << ch));
                chk("R3 discharge released", int'(discharge_on), 0);
                edges(m);
                exp = (m > MAXC) ? MAXC : m;
                chk("R4 running count", cnt(ch), exp);
                cmp_in[ch] = 1'b1;
                edges(2);
                read(1'b1, v);
                chk("R5 not stopped before third edge", v & (1 << ch), 0);
                edges(1);
                exp = (m + 2 > MAXC) ? MAXC : m + 2;
                chk("R5 frozen count", cnt(ch), exp);
                read(1'b1, v);
                chk("R9 stop flag bit", (v >> ch) & 1, 1);
                chk("R10 irq status bit", (v >> (4 + ch)) & 1, (m >> ch) & 1);
                chk("R10 irq output", int'(irq_req), ((m & 15) >> ch & 1) << ch);
                cmp_in[ch] = 1'b0;
                edges(3);
                cmp_in[ch] = 1'b1;
                edges(4);
                chk("R6 count held after new edge", cnt(ch), exp);
                read(1'b1, v);
                chk("R6 still stopped", (v >> ch) & 1, 1);
                wr(1'b0, 8'h00);
                edges(1);
                chk("R4 clear resets count", cnt(ch), 0);
                read(1'b1, v);
                chk("R4 clear resets stop", v, 0);
                cmp_in[ch] = 1'b0;
                edges(3);
            end
        end

        // R7 saturation without a trip
        irq_enable = 4'hF;
        wr(1'b0, 8'h01);
        edges(MAXC + 20);
        chk("R7 saturated", cnt(0), MAXC);
        edges(5);
        chk("R7 stays saturated", cnt(0), MAXC);
        chk("R7 no stop on saturation", int'(irq_req), 0);
        wr(1'b0, 8'h00);
        edges(1);

        // R8 rise while cleared, then level high at enable
        cmp_in[1] = 1'b1;
        edges(5);
        read(1'b1, v); chk("R8 no stop while cleared", v, 0);
        chk("R8 count stays zero", cnt(1), 0);
        wr(1'b0, 8'h02);
        edges(10);
        chk("R8 level does not stop", cnt(1), 10);
        read(1'b1, v); chk("R8 status clear with level high", v, 0);

        // R11 status write ignored
        wr(1'b0, 8'hA2);
        cmp_in[1] = 1'b0;
        edges(3);
        cmp_in[1] = 1'b1;
        edges(3);
        read(1'b1, v); chk("R11 setup stop set", v, 8'h22);
        wr(1'b1, 8'h00);
        read(1'b1, v); chk("R11 status unchanged", v, 8'h22);
        wr(1'b1, 8'hFF);
        read(1'b0, v); chk("R11 control unchanged", v, 8'hA2);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule